// File: doc/BRIEF.md
# Multi-Bank Video Memory Router

This block sits between a processor's memory bus and nine video RAM banks of different sizes. Each access is resolved to a set of banks, which may be empty. The resolution depends on which address window the access falls in and on the current contents of the mapping tables. Four windows, two for backgrounds and two for sprites, are looked up through per-slot tables of 9-bit bank-enable masks. A linear window places every bank at a fixed position, and each bank in it is gated by one enable bit. A secondary-processor port selects one of two slots, and either slot can hold only two particular banks.

More than one bank may be enabled for a slot. A read then returns the bitwise OR of every selected bank, and a write goes to all of them. The mapping tables are loaded through a small configuration write port. Read data is registered and appears one clock after the request.

Storage is scaled by the parameter `SLOT_BITS`, which is the log2 of the slot size in bytes. At 14 the slot is 16 KB and the address field positions are the full-size ones. The default of 6 keeps the bank arrays small. All window, table and layout positions below are written relative to `S` = `SLOT_BITS`, and the address is `S+10` bits wide.

Top module: `vram_router`

## Requirements
- R1: Address bits [S+9:S+7] pick the window when `acc_sec` is 0. The values are 0 = background A, 1 = background B, 2 = sprite A and 3 = sprite B. Values 4 to 7 select the linear window.
- R2: In a table window, the slot index is taken from address bits upward of bit S and wraps at the table length. The lengths are 32 for background A, 16 for sprite A, and 8 each for background B and sprite B.
- R3: A read returns the bitwise OR of the words of all selected banks. A read that selects no bank returns 0.
- R4: A write stores its data into every selected bank.
- R5: Each table keeps only the mask bits of banks its window may use. Background A may use banks 0-6, sprite A banks 0, 1, 4, 5 and 6, background B banks 2, 7 and 8, sprite B banks 3 and 8, and the secondary port banks 2 and 3. Other bits of a configuration mask have no effect.
- R6: The bank sizes are 8, 8, 8, 8, 4, 1, 1, 2 and 1 slots for banks 0 to 8. The word inside a bank is the address masked to that bank's size, so higher bits wrap onto the bank start.
- R7: In the linear window, slot field bits [S+5:S] place the banks back to back. Banks 0-3 take 8 slots each from slot 0. Bank 4 is at slot 32, bank 5 at 36, bank 6 at 37, bank 7 at 38 (2 slots) and bank 8 at 40.
- R8: A linear-window hit completes only when the bank's bit in the linear enable mask is set. Otherwise the read returns 0 and the write is dropped. Slots 41-63 behave the same way. Address bits [S+8:S+6] are ignored, so the layout mirrors.
- R9: A secondary-port access (`acc_sec`=1) uses address bit S+3 to choose one of two mask entries and ignores the window bits.
- R10: Byte lanes are little-endian. Size codes are 0 = byte, 1 = halfword, 2 or 3 = word. The address bits below the access size are ignored. Read results are zero-extended into `rd_data`.
- R11: `rd_data` updates on the clock edge that takes a read request and holds when no read is taken.
- R12: A configuration write takes effect at the next clock edge. An access in the same cycle uses the old mapping. `cfg_sel` codes are 0 = background A, 1 = background B, 2 = sprite A, 3 = sprite B, 4 = secondary port and 5 = linear enable mask; codes 6 and 7 are ignored.
- R13: Reset clears all mapping tables, the linear enable mask and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_sec | input | 1 | Access comes from the secondary-processor port |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_addr | input | SLOT_BITS+10 | Byte address |
| acc_wdata | input | 32 | Write data, right-aligned |
| rd_data | output | 32 | Registered read result |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Which table to load |
| cfg_idx | input | 5 | Table entry, wrapped to table length |
| cfg_mask | input | 9 | Bank mask, bit n = bank n |

## Verification
A configuration write and an access can arrive in the same cycle. The bench provokes this by raising the linear enable bit of a disabled bank on the same edge as a read of that bank. It expects 0, which is the old mapping, and then expects the stored data on the following read. That second read also shows that an earlier write to the disabled bank was dropped. Overlapping masks are exercised in the same way: direct writes to two banks are followed by a mapped read, which must return their OR. A broadcast write is then read back from each bank separately.

// File: rtl/vram_router_pkg.sv
package vram_router_pkg;

    localparam int NUM_BANKS = 9;
    localparam int DATA_W    = 32;

    typedef logic [NUM_BANKS-1:0] bank_mask_t;

    // table lengths, fixed by the address decode
    localparam int BGA_LEN = 32;
    localparam int SPA_LEN = 16;
    localparam int BGB_LEN = 8;
    localparam int SPB_LEN = 8;
    localparam int SEC_LEN = 2;

    // banks each window may reach
    localparam bank_mask_t ALLOW_BGA = 9'h07F;
    localparam bank_mask_t ALLOW_SPA = 9'h073;
    localparam bank_mask_t ALLOW_BGB = 9'h184;
    localparam bank_mask_t ALLOW_SPB = 9'h108;
    localparam bank_mask_t ALLOW_SEC = 9'h00C;

    // configuration targets
    localparam logic [2:0] CFG_BGA = 3'd0;
    localparam logic [2:0] CFG_BGB = 3'd1;
    localparam logic [2:0] CFG_SPA = 3'd2;
    localparam logic [2:0] CFG_SPB = 3'd3;
    localparam logic [2:0] CFG_SEC = 3'd4;
    localparam logic [2:0] CFG_LIN = 3'd5;

    // access sizes
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    typedef struct packed {
        bank_mask_t [BGA_LEN-1:0] bga;
        bank_mask_t [SPA_LEN-1:0] spa;
        bank_mask_t [BGB_LEN-1:0] bgb;
        bank_mask_t [SPB_LEN-1:0] spb;
        bank_mask_t [SEC_LEN-1:0] sec;
        bank_mask_t               lin_en;
    } map_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] rd_data;
    } port_state_t;

    // size of each bank in slots
    function automatic int bank_slots(input int b);
        case (b)
            0, 1, 2, 3: return 8;
            4:          return 4;
            7:          return 2;
            default:    return 1;
        endcase
    endfunction

    // first slot of each bank in the linear window
    function automatic int bank_base(input int b);
        case (b)
            0:       return 0;
            1:       return 8;
            2:       return 16;
            3:       return 24;
            4:       return 32;
            5:       return 36;
            6:       return 37;
            7:       return 38;
            default: return 40;
        endcase
    endfunction

endpackage

// File: rtl/vram_map_tables.sv
module vram_map_tables
    import vram_router_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_sel,
    input  logic [4:0] cfg_idx,
    input  bank_mask_t cfg_mask,
    input  logic       acc_sec,
    input  logic [2:0] win,
    input  logic [5:0] slot,
    output bank_mask_t sel_mask
);

    map_state_t st_d, st_q;
    bank_mask_t lin_hit;

    // configuration: masks are filtered to the window's banks on entry
    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            case (cfg_sel)
                CFG_BGA: st_d.bga[cfg_idx]      = cfg_mask & ALLOW_BGA;
                CFG_SPA: st_d.spa[cfg_idx[3:0]] = cfg_mask & ALLOW_SPA;
                CFG_BGB: st_d.bgb[cfg_idx[2:0]] = cfg_mask & ALLOW_BGB;
                CFG_SPB: st_d.spb[cfg_idx[2:0]] = cfg_mask & ALLOW_SPB;
                CFG_SEC: st_d.sec[cfg_idx[0]]   = cfg_mask & ALLOW_SEC;
                CFG_LIN: st_d.lin_en            = cfg_mask;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // linear layout decode
    always_comb begin
        lin_hit = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(slot) >= bank_base(b) && int'(slot) < bank_base(b) + bank_slots(b))
                lin_hit[b] = 1'b1;
        end
    end

    // access resolution
    always_comb begin
        sel_mask = '0;
        if (acc_sec) begin
            sel_mask = st_q.sec[slot[3]];
        end else if (win[2]) begin
            sel_mask = lin_hit & st_q.lin_en;
        end else begin
            case (win[1:0])
                2'd0:    sel_mask = st_q.bga[slot[4:0]];
                2'd1:    sel_mask = st_q.bgb[slot[2:0]];
                2'd2:    sel_mask = st_q.spa[slot[3:0]];
                default: sel_mask = st_q.spb[slot[2:0]];
            endcase
        end
    end

    a_r12_cfg_bga_applied: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_sel == CFG_BGA |=> st_q.bga[$past(cfg_idx)] == ($past(cfg_mask) & ALLOW_BGA));

    a_r5_bgb_filtered: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_sec && win == 3'd1 |-> (sel_mask & ~ALLOW_BGB) == '0);

    a_r9_sec_banks_only: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sec |-> (sel_mask & ~ALLOW_SEC) == '0);

    a_r7_linear_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_sec && win[2] |-> $onehot0(sel_mask));

    a_r13_reset_clears_linear: assert property (@(posedge clk)
        !rst_n |=> st_q.lin_en == '0);

endmodule

// File: rtl/vram_lane.sv
module vram_lane
    import vram_router_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        byte_off,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] wr_word,
    output logic [3:0]        wr_be,
    output logic [DATA_W-1:0] rd_val
);

    logic [1:0]        off;
    logic [DATA_W-1:0] keep;

    always_comb begin
        case (size)
            SZ_BYTE: begin
                off     = byte_off;
                wr_be   = 4'b0001 << off;
                wr_word = {4{wdata[7:0]}};
                keep    = 32'h0000_00FF;
            end
            SZ_HALF: begin
                off     = {byte_off[1], 1'b0};
                wr_be   = 4'b0011 << off;
                wr_word = {2{wdata[15:0]}};
                keep    = 32'h0000_FFFF;
            end
            default: begin
                off     = 2'd0;
                wr_be   = 4'b1111;
                wr_word = wdata;
                keep    = 32'hFFFF_FFFF;
            end
        endcase
        rd_val = (rd_word >> {off, 3'b000}) & keep;
    end

endmodule

// File: rtl/vram_bank.sv
module vram_bank #(
    parameter  int SLOT_BITS = 6,
    parameter  int SLOTS     = 1,
    localparam int IW        = $clog2(SLOTS) + SLOT_BITS - 2,
    localparam int WORDS     = 1 << IW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [3:0]    wr_be,
    input  logic [31:0]   wr_word,
    input  logic [IW-1:0] word_idx,
    output logic [31:0]   rd_word
);

    logic [31:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < 4; i++) begin
                if (wr_be[i]) mem_q[word_idx][8*i +: 8] <= wr_word[8*i +: 8];
            end
        end
    end

    assign rd_word = mem_q[word_idx];

endmodule

// File: rtl/vram_router.sv
module vram_router
    import vram_router_pkg::*;
#(
    parameter  int SLOT_BITS = 6,
    localparam int AW        = SLOT_BITS + 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              acc_we,
    input  logic              acc_sec,
    input  logic [1:0]        acc_size,
    input  logic [AW-1:0]     acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [4:0]        cfg_idx,
    input  logic [8:0]        cfg_mask
);

    port_state_t       st_d, st_q;
    bank_mask_t        sel_mask;
    logic [DATA_W-1:0] wr_word, rd_val, or_word;
    logic [3:0]        wr_be;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];
    logic              mirror_bit_unused;

    // bit S+6 is part of the ignored mirror field and of no table index
    assign mirror_bit_unused = acc_addr[SLOT_BITS+6];

    vram_map_tables u_tables (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_idx  (cfg_idx),
        .cfg_mask (cfg_mask),
        .acc_sec  (acc_sec),
        .win      (acc_addr[AW-1:AW-3]),
        .slot     (acc_addr[SLOT_BITS+5:SLOT_BITS]),
        .sel_mask (sel_mask)
    );

    vram_lane u_lane (
        .size     (acc_size),
        .byte_off (acc_addr[1:0]),
        .wdata    (acc_wdata),
        .rd_word  (or_word),
        .wr_word  (wr_word),
        .wr_be    (wr_be),
        .rd_val   (rd_val)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int SL   = bank_slots(b);
        localparam int IW_B = $clog2(SL) + SLOT_BITS - 2;
        logic we_b;
        assign we_b = acc_req && acc_we && sel_mask[b];
        vram_bank #(.SLOT_BITS(SLOT_BITS), .SLOTS(SL)) u_bank (
            .clk      (clk),
            .wr_en    (we_b),
            .wr_be    (wr_be),
            .wr_word  (wr_word),
            .word_idx (acc_addr[IW_B+1:2]),
            .rd_word  (bank_rd[b])
        );
    end

    // overlapping banks merge by OR
    always_comb begin
        or_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel_mask[b]) or_word = or_word | bank_rd[b];
        end
    end

    always_comb begin
        st_d = st_q;
        if (acc_req && !acc_we) st_d.rd_data = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd_data;

    a_r3_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_we && sel_mask == '0 |=> rd_data == '0);

    a_r10_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_we && acc_size == SZ_BYTE |=> rd_data[31:8] == '0);

    a_r10_half_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !acc_we && acc_size == SZ_HALF |=> rd_data[31:16] == '0);

    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_req && !acc_we) |=> $stable(rd_data));

endmodule

// File: tb/tb_vram_router.sv
module tb_vram_router;
    import vram_router_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_req, acc_we, acc_sec;
    logic [1:0]  acc_size;
    logic [15:0] acc_addr;
    logic [31:0] acc_wdata;
    logic [31:0] rd_data;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [4:0]  cfg_idx;
    logic [8:0]  cfg_mask;

    int n_checks = 0;
    int n_errs   = 0;

    always #4 clk = ~clk;

    vram_router dut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
        .acc_sec(acc_sec), .acc_size(acc_size), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .rd_data(rd_data), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_mask(cfg_mask)
    );

    typedef struct packed {
        logic        sec;
        logic        we;
        logic [1:0]  sz;
        logic [2:0]  win;
        logic [6:0]  slot;
        logic [5:0]  off;
        logic [31:0] wd;
        logic [31:0] ex;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b1,2'd2,3'd0,7'd0, 6'h00,32'h11223344,32'h0,       8'd4 },
        '{1'b0,1'b0,2'd2,3'd0,7'd0, 6'h00,32'h0,       32'h11223344,8'd1 },  // R1
        '{1'b0,1'b0,2'd2,3'd4,7'd0, 6'h00,32'h0,       32'h11223344,8'd7 },  // R7
        '{1'b0,1'b1,2'd2,3'd0,7'd1, 6'h04,32'hAABBCCDD,32'h0,       8'd4 },
        '{1'b0,1'b0,2'd2,3'd4,7'd33,6'h04,32'h0,       32'hAABBCCDD,8'd7 },
        '{1'b0,1'b1,2'd2,3'd4,7'd2, 6'h08,32'h000000F0,32'h0,       8'd7 },
        '{1'b0,1'b1,2'd2,3'd4,7'd10,6'h08,32'h0F000000,32'h0,       8'd7 },
        '{1'b0,1'b0,2'd2,3'd0,7'd2, 6'h08,32'h0,       32'h0F0000F0,8'd3 },  // R3 OR merge
        '{1'b0,1'b1,2'd2,3'd0,7'd2, 6'h08,32'h12345678,32'h0,       8'd4 },
        '{1'b0,1'b0,2'd2,3'd4,7'd2, 6'h08,32'h0,       32'h12345678,8'd4 },  // R4 broadcast
        '{1'b0,1'b0,2'd2,3'd4,7'd10,6'h08,32'h0,       32'h12345678,8'd4 },
        '{1'b0,1'b0,2'd2,3'd0,7'd32,6'h00,32'h0,       32'h11223344,8'd2 },  // R2 wrap
        '{1'b0,1'b1,2'd2,3'd4,7'd1, 6'h10,32'h0BAD0BAD,32'h0,       8'd5 },
        '{1'b0,1'b1,2'd2,3'd1,7'd1, 6'h10,32'hCAFEF00D,32'h0,       8'd4 },
        '{1'b0,1'b0,2'd2,3'd4,7'd39,6'h10,32'h0,       32'hCAFEF00D,8'd6 },
        '{1'b0,1'b0,2'd2,3'd4,7'd40,6'h10,32'h0,       32'hCAFEF00D,8'd6 },  // R6 wrap
        '{1'b0,1'b0,2'd2,3'd4,7'd1, 6'h10,32'h0,       32'h0BAD0BAD,8'd5 },  // R5 bank0 bit dropped
        '{1'b0,1'b1,2'd2,3'd4,7'd0, 6'h0C,32'hDEAD0000,32'h0,       8'd9 },
        '{1'b1,1'b1,2'd2,3'd0,7'd0, 6'h0C,32'h5A5A5A5A,32'h0,       8'd9 },
        '{1'b0,1'b0,2'd2,3'd1,7'd0, 6'h0C,32'h0,       32'h5A5A5A5A,8'd9 },  // R9
        '{1'b0,1'b0,2'd2,3'd4,7'd0, 6'h0C,32'h0,       32'hDEAD0000,8'd9 },
        '{1'b1,1'b1,2'd2,3'd0,7'd8, 6'h00,32'h00000077,32'h0,       8'd9 },
        '{1'b0,1'b0,2'd2,3'd3,7'd0, 6'h00,32'h0,       32'h00000077,8'd9 },
        '{1'b0,1'b0,2'd2,3'd2,7'd2, 6'h08,32'h0,       32'h12345678,8'd1 },
        '{1'b0,1'b0,2'd2,3'd2,7'd18,6'h08,32'h0,       32'h12345678,8'd2 },
        '{1'b0,1'b1,2'd0,3'd0,7'd0, 6'h01,32'h000000EE,32'h0,       8'd10},  // R10 lanes
        '{1'b0,1'b0,2'd2,3'd0,7'd0, 6'h00,32'h0,       32'h1122EE44,8'd10},
        '{1'b0,1'b0,2'd0,3'd0,7'd0, 6'h03,32'h0,       32'h00000011,8'd10},
        '{1'b0,1'b0,2'd1,3'd0,7'd0, 6'h02,32'h0,       32'h00001122,8'd10},
        '{1'b0,1'b1,2'd1,3'd0,7'd0, 6'h02,32'h0000BEEF,32'h0,       8'd10},
        '{1'b0,1'b0,2'd1,3'd0,7'd0, 6'h03,32'h0,       32'h0000BEEF,8'd10},
        '{1'b0,1'b0,2'd0,3'd0,7'd0, 6'h00,32'h0,       32'h00000044,8'd10},
        '{1'b0,1'b0,2'd2,3'd7,7'd64,6'h00,32'h0,       32'hBEEFEE44,8'd8 },  // R8 mirror
        '{1'b0,1'b1,2'd2,3'd0,7'd3, 6'h20,32'h00C0FFEE,32'h0,       8'd4 },
        '{1'b0,1'b0,2'd2,3'd0,7'd3, 6'h20,32'h0,       32'h00C0FFEE,8'd3 },
        '{1'b0,1'b0,2'd2,3'd4,7'd36,6'h20,32'h0,       32'h00C0FFEE,8'd7 },
        '{1'b0,1'b0,2'd2,3'd4,7'd37,6'h20,32'h0,       32'h00000000,8'd8 },
        '{1'b0,1'b1,2'd2,3'd4,7'd37,6'h20,32'hFFFFFFFF,32'h0,       8'd8 },
        '{1'b0,1'b0,2'd2,3'd0,7'd3, 6'h20,32'h0,       32'h00C0FFEE,8'd4 },
        '{1'b0,1'b0,2'd2,3'd0,7'd4, 6'h00,32'h0,       32'h00000000,8'd3 },
        '{1'b0,1'b0,2'd2,3'd4,7'd50,6'h00,32'h0,       32'h00000000,8'd8 }
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [4:0] idx, input logic [8:0] m);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic sec, input logic we, input logic [1:0] sz,
                          input logic [15:0] a, input logic [31:0] wd);
        acc_req = 1'b1; acc_sec = sec; acc_we = we; acc_size = sz;
        acc_addr = a; acc_wdata = wd;
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; acc_req = 1'b0; acc_we = 1'b0; acc_sec = 1'b0;
        acc_size = 2'd0; acc_addr = '0; acc_wdata = '0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_idx = '0; cfg_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: reset state
        check("R13 rd_data after reset", rd_data, 32'h0);
        access(1'b0, 1'b0, 2'd2, {3'd0, 7'd0, 6'h00}, 32'h0);
        check("R13 table cleared", rd_data, 32'h0);
        access(1'b0, 1'b0, 2'd2, {3'd4, 7'd0, 6'h00}, 32'h0);
        check("R13 linear enable cleared", rd_data, 32'h0);

        // mapping set-up; several masks carry bits their window may not use (R5)
        cfg_write(CFG_BGA, 5'd0, 9'h001);
        cfg_write(CFG_BGA, 5'd1, 9'h010);
        cfg_write(CFG_BGA, 5'd2, 9'h003);
        cfg_write(CFG_BGA, 5'd3, 9'h1FF);
        cfg_write(CFG_SPA, 5'd2, 9'h002);
        cfg_write(CFG_BGB, 5'd0, 9'h004);
        cfg_write(CFG_BGB, 5'd1, 9'h181);
        cfg_write(CFG_SPB, 5'd0, 9'h008);
        cfg_write(CFG_SEC, 5'd0, 9'h005);
        cfg_write(CFG_SEC, 5'd1, 9'h008);
        cfg_write(CFG_LIN, 5'd0, 9'h1BF);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].sec, VEC[i].we, VEC[i].sz,
                   {VEC[i].win, VEC[i].slot, VEC[i].off}, VEC[i].wd);
            if (!VEC[i].we)
                check($sformatf("R%0d vector %0d", VEC[i].req, i), rd_data, VEC[i].ex);
        end

        // R12: configuration write and read on the same edge see the old mapping
        cfg_we = 1'b1; cfg_sel = CFG_LIN; cfg_idx = 5'd0; cfg_mask = 9'h1FF;
        access(1'b0, 1'b0, 2'd2, {3'd4, 7'd37, 6'h20}, 32'h0);
        cfg_we = 1'b0;
        check("R12 same-cycle read uses old mapping", rd_data, 32'h0);
        access(1'b0, 1'b0, 2'd2, {3'd4, 7'd37, 6'h20}, 32'h0);
        check("R8 dropped write left bank intact", rd_data, 32'h00C0FFEE);

        // R11: hold while idle, then one-cycle latency
        repeat (2) @(negedge clk);
        check("R11 hold while idle", rd_data, 32'h00C0FFEE);
        acc_req = 1'b1; acc_we = 1'b0; acc_sec = 1'b0; acc_size = 2'd2;
        acc_addr = {3'd0, 7'd4, 6'h00};
        #1;
        check("R11 no change before edge", rd_data, 32'h00C0FFEE);
        @(negedge clk);
        acc_req = 1'b0;
        check("R11 updated after edge", rd_data, 32'h0);

        // R12: ignored configuration code leaves tables as they were
        cfg_write(3'd6, 5'd0, 9'h000);
        access(1'b0, 1'b0, 2'd2, {3'd0, 7'd0, 6'h00}, 32'h0);
        check("R12 ignored cfg code", rd_data, 32'hBEEFEE44);

        summary();
        $finish;
    end

endmodule